// File: doc/BRIEF.md
# Serial EEPROM Identity Loader

After a hardware reset this block reads two identity words from an external serial EEPROM, with no host action needed. It uses a four-wire link: select, serial clock, command data to the device, and read data from the device. The first word becomes the 16-bit vendor identity and the second becomes the 16-bit device identity. Both identity outputs hold built-in default values from reset. A device that does not answer, or a blank first word, leaves those defaults in place.

A done flag rises when loading ends, whether the words were loaded or the defaults were kept. The flag then stays set until the next reset. Until it is set, every configuration read request is answered with a retry, so the host never sees an identity that is only partly loaded.

Each word is read with one frame. The frame sends a start bit of 1, then opcode `10`, then a 6-bit word address, all MSB first. The device then returns one dummy 0 bit and 16 data bits, also MSB first. The command bits change while the serial clock is low, and the block samples returned bits when the clock falls. The loader is one state machine with five states:

- `LD_IDLE` waits one clock phase and then opens the first frame (IDLE→BIT_LOW).
- `LD_BIT_LOW` and `LD_BIT_HIGH` alternate for every bit (LOW→HIGH, HIGH→LOW).
- From `LD_BIT_HIGH` the machine leaves in three ways. If the dummy bit reads 1, it aborts (HIGH→DONE). If the vendor word is complete, it goes to the gap (HIGH→GAP). If the device word is complete, it finishes (HIGH→DONE).
- `LD_GAP` holds select low for two clock phases and then opens the second frame (GAP→BIT_LOW).
- `LD_DONE` is terminal.

Top module: `ee_id_loader`

## Requirements
- R1: After reset is released, select rises within 2*SK_HALF+2 clock cycles, with no input activity. load_done stays 0 until the load ends.
- R2: Each frame shifts out 9 command bits MSB first on ee_di, captured by the device on rising ee_sk: 1, 1, 0, then the 6-bit address. The first frame uses address 0 (9'h180) and the second uses address 1 (9'h181).
- R3: The 16 bits returned after the dummy bit, MSB first, are loaded into vendor_id from address 0 and into device_id from address 1.
- R4: Each high phase and each low phase of ee_sk lasts at least SK_HALF clock cycles. The default of 100 gives a serial clock of 1 MHz or less at 200 MHz.
- R5: Between the two frames, select stays low for at least 2*SK_HALF cycles, which is one full serial clock period. ee_sk is never high while select is low.
- R6: If the dummy bit of the first frame reads 1 (no device present), loading stops after that frame and both identities keep their defaults.
- R7: If the first word reads 16'hFFFF, both identities keep their defaults and no second frame is issued.
- R8: load_done, once set, stays set until reset. While it is set, select and ee_sk are low.
- R9: cfg_rd_retry is 1 while cfg_rd_req is 1 and load_done is 0. It is 0 once load_done is set.
- R10: From reset until replaced, vendor_id equals DEF_VENDOR and device_id equals DEF_DEVICE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| ee_do | input | 1 | Serial read data from the EEPROM (pulled high when idle) |
| ee_cs | output | 1 | EEPROM select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial command data to the EEPROM |
| vendor_id | output | DATA_W | Vendor identity value |
| device_id | output | DATA_W | Device identity value |
| load_done | output | 1 | Loading finished |
| cfg_rd_req | input | 1 | Configuration read request from the bus side |
| cfg_rd_retry | output | 1 | The request must be retried |

## Verification
The assertions check these properties on every cycle:
- the serial clock moves only on a divider tick;
- select stays low for at least a full serial period between frames;
- the done flag holds, and the link stays quiet once it is set;
- retries never coexist with done;
- a failed dummy bit leads at once to done with the defaults kept.

Only the bench scenarios can show the rest, because each needs an EEPROM model answering in a particular way:
- the exact command bits each frame carries;
- the identity values assembled from the returned bits;
- the absent-device fallback;
- the blank-word fallback;
- the automatic start after reset.

// File: rtl/ee_loader_pkg.sv
package ee_loader_pkg;
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_BIT_LOW,
        LD_BIT_HIGH,
        LD_GAP,
        LD_DONE
    } ld_state_t;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/ee_sk_tick.sv
module ee_sk_tick #(
    parameter int HALF = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ee_read_frame.sv
module ee_read_frame
    import ee_loader_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              step,
    input  logic              so,
    output logic              si,
    output logic              at_dummy,
    output logic              at_last,
    output logic [DATA_W-1:0] word_next
);
    localparam int CMD_W = 3 + ADDR_W;
    localparam int TOTAL = CMD_W + DATA_W;
    localparam int IW    = $clog2(TOTAL + 1);

    logic [CMD_W-1:0]  cmd_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (start) begin
            cmd_q  <= {1'b1, OP_READ, addr};
            idx_q  <= '0;
            data_q <= '0;
        end else if (step) begin
            cmd_q <= cmd_q << 1;
            idx_q <= idx_q + 1'b1;
            if (idx_q >= IW'(CMD_W))
                data_q <= word_next;
        end
    end

    assign si        = (idx_q < IW'(CMD_W)) ? cmd_q[CMD_W-1] : 1'b0;
    assign at_dummy  = (idx_q == IW'(CMD_W - 1));
    assign at_last   = (idx_q == IW'(TOTAL - 1));
    assign word_next = {data_q[DATA_W-2:0], so};

    // R3: the bit index never runs past one frame
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IW'(TOTAL))
        else $error("bit index beyond frame");
endmodule

// File: rtl/ee_id_loader.sv
module ee_id_loader
    import ee_loader_pkg::*;
#(
    parameter int              SK_HALF     = 100,
    parameter int              ADDR_W      = 6,
    parameter int              DATA_W      = 16,
    parameter logic [DATA_W-1:0] DEF_VENDOR = 16'h1D0C,
    parameter logic [DATA_W-1:0] DEF_DEVICE = 16'h0103,
    parameter int              VENDOR_ADDR = 0,
    parameter int              DEVICE_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [DATA_W-1:0] vendor_id,
    output logic [DATA_W-1:0] device_id,
    output logic              load_done,
    input  logic              cfg_rd_req,
    output logic              cfg_rd_retry
);
    localparam int GAP_MIN = 2 * SK_HALF;
    localparam int GW      = $clog2(GAP_MIN + 1);

    ld_state_t         state_q, state_d;
    logic              word_sel_q;
    logic              gap_q;
    logic              tick;
    logic              frame_start, step, take_vendor, take_device, gap_inc;
    logic              si, at_dummy, at_last;
    logic [DATA_W-1:0] word_next;
    logic [ADDR_W-1:0] frame_addr;

    ee_sk_tick #(.HALF(SK_HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign frame_addr = word_sel_q ? ADDR_W'(DEVICE_ADDR) : ADDR_W'(VENDOR_ADDR);

    ee_read_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frame_start),
        .addr     (frame_addr),
        .step     (step),
        .so       (ee_do),
        .si       (si),
        .at_dummy (at_dummy),
        .at_last  (at_last),
        .word_next(word_next)
    );

    // next state and control strobes
    always_comb begin
        state_d     = state_q;
        frame_start = 1'b0;
        step        = 1'b0;
        take_vendor = 1'b0;
        take_device = 1'b0;
        gap_inc     = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (tick) begin
                    state_d     = LD_BIT_LOW;
                    frame_start = 1'b1;
                end
            end
            LD_BIT_LOW: begin
                if (tick)
                    state_d = LD_BIT_HIGH;
            end
            LD_BIT_HIGH: begin
                if (tick) begin
                    step = 1'b1;
                    if (at_dummy && ee_do) begin
                        state_d = LD_DONE;
                    end else if (at_last) begin
                        if (!word_sel_q) begin
                            if (word_next == '1) begin
                                state_d = LD_DONE;
                            end else begin
                                take_vendor = 1'b1;
                                state_d     = LD_GAP;
                            end
                        end else begin
                            take_device = 1'b1;
                            state_d     = LD_DONE;
                        end
                    end else begin
                        state_d = LD_BIT_LOW;
                    end
                end
            end
            LD_GAP: begin
                if (tick) begin
                    if (gap_q) begin
                        state_d     = LD_BIT_LOW;
                        frame_start = 1'b1;
                    end else begin
                        gap_inc = 1'b1;
                    end
                end
            end
            LD_DONE: state_d = LD_DONE;
            default: state_d = LD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LD_IDLE;
        else
            state_q <= state_d;
    end

    // identity and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vendor_id  <= DEF_VENDOR;
            device_id  <= DEF_DEVICE;
            word_sel_q <= 1'b0;
            gap_q      <= 1'b0;
        end else begin
            if (take_vendor) begin
                vendor_id  <= word_next;
                word_sel_q <= 1'b1;
            end
            if (take_device)
                device_id <= word_next;
            if (gap_inc)
                gap_q <= 1'b1;
            else if (frame_start)
                gap_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ee_cs     = 1'b0;
        ee_sk     = 1'b0;
        load_done = 1'b0;
        unique case (state_q)
            LD_IDLE:     ;
            LD_BIT_LOW:  ee_cs = 1'b1;
            LD_BIT_HIGH: begin
                ee_cs = 1'b1;
                ee_sk = 1'b1;
            end
            LD_GAP:      ;
            LD_DONE:     load_done = 1'b1;
            default:     ;
        endcase
        ee_di        = ee_cs & si;
        cfg_rd_retry = cfg_rd_req & ~load_done;
    end

    // checker state: cycles with select low since it last fell
    logic [GW-1:0] cs_low_cnt_q;
    logic          seen_cs_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_low_cnt_q <= '0;
            seen_cs_q    <= 1'b0;
        end else begin
            if (ee_cs) begin
                cs_low_cnt_q <= '0;
                seen_cs_q    <= 1'b1;
            end else if (cs_low_cnt_q < GW'(GAP_MIN)) begin
                cs_low_cnt_q <= cs_low_cnt_q + 1'b1;
            end
        end
    end

    // R4: serial clock only moves after a divider tick
    p_sk_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk != $past(ee_sk)) |-> $past(tick))
        else $error("serial clock moved without tick");

    // R5: select low for a full serial period between frames
    p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ee_cs) && seen_cs_q) |-> (cs_low_cnt_q >= GW'(GAP_MIN)))
        else $error("select gap too short");

    // R5: no serial clock while deselected
    p_sk_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs)
        else $error("clock while deselected");

    // R6: a missing device ends the load with defaults
    p_dummy_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_BIT_HIGH && tick && at_dummy && ee_do && !word_sel_q)
        |=> (load_done && vendor_id == DEF_VENDOR && device_id == DEF_DEVICE))
        else $error("absent device not handled");

    // R8: done is sticky and the link is quiet
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done)
        else $error("done dropped");

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!ee_cs && !ee_sk))
        else $error("link active after done");

    // R9: retries only before done
    p_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_retry |-> !load_done)
        else $error("retry after done");
endmodule

// File: tb/ee_id_loader_tb.sv
module ee_id_loader_tb;
    localparam int SK_HALF = 100;
    localparam logic [15:0] DEF_V = 16'h1D0C;
    localparam logic [15:0] DEF_D = 16'h0103;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_do;
    logic ee_cs, ee_sk, ee_di;
    logic [15:0] vendor_id, device_id;
    logic load_done;
    logic cfg_rd_req = 1'b0;
    logic cfg_rd_retry;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ee_id_loader #(
        .SK_HALF(SK_HALF), .ADDR_W(6), .DATA_W(16),
        .DEF_VENDOR(DEF_V), .DEF_DEVICE(DEF_D),
        .VENDOR_ADDR(0), .DEVICE_ADDR(1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ee_do(ee_do),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .vendor_id(vendor_id), .device_id(device_id),
        .load_done(load_done),
        .cfg_rd_req(cfg_rd_req), .cfg_rd_retry(cfg_rd_retry)
    );

    // EEPROM model
    logic        m_present = 1'b1;
    logic [15:0] m_mem0 = 16'h0000;
    logic [15:0] m_mem1 = 16'h0000;
    logic        m_do = 1'b1;
    int          m_bitn = 0;
    int          m_frames = 0;
    logic [8:0]  m_cmd = '0;
    logic [8:0]  cmd_log [0:3];

    assign ee_do = m_do;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            m_bitn = 0;
            m_do   = 1'b1;
        end else begin
            logic [15:0] w;
            m_bitn = m_bitn + 1;
            if (m_bitn <= 9) m_cmd = {m_cmd[7:0], ee_di};
            w = (m_cmd[5:0] == 6'd0) ? m_mem0 : (m_cmd[5:0] == 6'd1) ? m_mem1 : 16'hFFFF;
            if (m_bitn == 9) begin
                if (m_frames < 4) cmd_log[m_frames] = m_cmd;
                m_frames = m_frames + 1;
                m_do = m_present ? 1'b0 : 1'b1;
            end else if (m_bitn >= 10 && m_bitn <= 25) begin
                m_do = m_present ? w[25 - m_bitn] : 1'b1;
            end else begin
                m_do = 1'b1;
            end
        end
    end

    // timing monitor
    int   cyc = 0;
    int   last_edge = 0;
    bit   have_edge = 0;
    int   cs_fall = 0;
    bit   had_fall = 0;
    int   min_half = 1000000;
    int   min_gap = 1000000;
    int   sk_bad = 0;
    logic prev_sk = 1'b0;
    logic prev_cs = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (ee_sk != prev_sk && prev_cs) begin
                if (have_edge && (cyc - last_edge) < min_half) min_half = cyc - last_edge;
                last_edge = cyc;
                have_edge = 1;
            end
            if (ee_cs && !prev_cs) begin
                if (had_fall && (cyc - cs_fall) < min_gap) min_gap = cyc - cs_fall;
                last_edge = cyc;
                have_edge = 1;
            end
            if (!ee_cs && prev_cs) begin
                have_edge = 0;
                cs_fall   = cyc;
                had_fall  = 1;
            end
            if (ee_sk && !ee_cs) sk_bad = sk_bad + 1;
        end
        prev_sk = ee_sk;
        prev_cs = ee_cs;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_frames = 0;
        min_half = 1000000;
        min_gap = 1000000;
        sk_bad = 0;
        had_fall = 0;
        have_edge = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!load_done && n < 60000) begin
            @(negedge clk);
            n++;
        end
        check(load_done == 1'b1, "R8 done reached", load_done, 1);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(vendor_id == DEF_V, "R10 vendor default in reset", vendor_id, DEF_V);
        check(device_id == DEF_D, "R10 device default in reset", device_id, DEF_D);
        check(load_done == 1'b0, "R1 done low in reset", load_done, 0);
        check(ee_cs == 1'b0 && ee_sk == 1'b0, "R8 link idle in reset", {ee_cs, ee_sk}, 0);
    endtask

    task automatic t_normal(input logic [15:0] v, input logic [15:0] d);
        int wait_c = 0;
        bit done_early = 0;
        m_present = 1'b1;
        m_mem0 = v;
        m_mem1 = d;
        do_reset();
        while (!ee_cs && wait_c < 5 * SK_HALF) begin
            if (load_done) done_early = 1;
            @(negedge clk);
            wait_c++;
        end
        check(wait_c <= 2 * SK_HALF + 2, "R1 auto start", wait_c, 2 * SK_HALF + 2);
        check(!done_early && !load_done, "R1 done low during load", load_done, 0);
        // R9: retry while loading
        cfg_rd_req = 1'b1;
        #1;
        check(cfg_rd_retry == 1'b1, "R9 retry while loading", cfg_rd_retry, 1);
        check(vendor_id == DEF_V, "R10 vendor default before load", vendor_id, DEF_V);
        cfg_rd_req = 1'b0;
        wait_done();
        check(vendor_id == v, "R3 vendor loaded", vendor_id, v);
        check(device_id == d, "R3 device loaded", device_id, d);
        check(m_frames == 2, "R2 two frames", m_frames, 2);
        check(cmd_log[0] == 9'h180, "R2 first command", cmd_log[0], 9'h180);
        check(cmd_log[1] == 9'h181, "R2 second command", cmd_log[1], 9'h181);
        check(min_half >= SK_HALF, "R4 half period", min_half, SK_HALF);
        check(min_gap >= 2 * SK_HALF, "R5 select gap", min_gap, 2 * SK_HALF);
        check(sk_bad == 0, "R5 clock while deselected", sk_bad, 0);
        cfg_rd_req = 1'b1;
        #1;
        check(cfg_rd_retry == 1'b0, "R9 no retry after done", cfg_rd_retry, 0);
        cfg_rd_req = 1'b0;
        repeat (3 * SK_HALF) @(negedge clk);
        check(load_done == 1'b1 && !ee_cs && !ee_sk, "R8 done sticky and quiet",
              {load_done, ee_cs, ee_sk}, 3'b100);
        check(vendor_id == v && device_id == d, "R3 ids hold", {vendor_id, device_id}, {v, d});
    endtask

    task automatic t_absent();
        m_present = 1'b0;
        m_mem0 = 16'h1234;
        m_mem1 = 16'h5678;
        do_reset();
        wait_done();
        check(vendor_id == DEF_V, "R6 vendor default", vendor_id, DEF_V);
        check(device_id == DEF_D, "R6 device default", device_id, DEF_D);
        check(m_frames == 1, "R6 single frame", m_frames, 1);
        m_present = 1'b1;
    endtask

    task automatic t_blank();
        m_present = 1'b1;
        m_mem0 = 16'hFFFF;
        m_mem1 = 16'h4321;
        do_reset();
        wait_done();
        check(vendor_id == DEF_V, "R7 vendor default", vendor_id, DEF_V);
        check(device_id == DEF_D, "R7 device default", device_id, DEF_D);
        check(m_frames == 1, "R7 no second frame", m_frames, 1);
    endtask

    bit finished = 0;

    initial begin
        t_reset_state();
        t_normal(16'hA5C3, 16'h0F1E);
        t_normal(16'h0001, 16'h8000);
        t_normal(16'hFFFE, 16'hFFFF);
        t_absent();
        t_blank();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule